// File: doc/BRIEF.md
# Card Clock Divider with Update Handshake

This block derives a card clock from the system clock. It uses a programmable even divider and a run/stop control. Host writes to the divider and run fields go into staged copies first, and the running clock is untouched at that point. The staged values reach the divider only when the host writes a clock-update command word to the command port. The block then holds the command start bit at 1 and lowers it by itself once the new values are in force. This gives software one completion bit to poll after each clock change.

The divider runs in the system clock domain and drives a card-clock level together with a one-cycle rising-edge enable (`cclk_tick`). A half period lasts N system cycles, so a full card-clock period is 2N cycles. A divider value of 0 asserts the enable on every cycle. A new setting is applied only while the card-clock level is low, so the output never produces a shortened pulse. A clock-update command can ask to wait for the data path: the update is then held while the external busy input is high. If the host writes the command port again while a start is still pending, a sticky locked-error flag is raised. The host clears that flag with a write-one-to-clear.

Top module: `cardclk_gen`

## Requirements
- R1: After reset, `cmd_start`, `hle_flag`, `ena_active`, `cclk_level` and `cclk_tick` are 0 and `div_active` is 0.
- R2: A write to the command port (`wr_sel`=2) with bit 31 and bit 21 both set, made while `cmd_start` is 0, sets `cmd_start` to 1 from the next cycle. When `cmd_start` later falls, `div_active`/`ena_active` equal the staged divider and run values. They do not change before that fall.
- R3: Writes to the staged divider (`wr_sel`=0, bits 7:0) and run bit (`wr_sel`=1, bit 0) leave `div_active` and `ena_active` unchanged until an update command completes.
- R4: With no wait condition and the card-clock level low, `cmd_start` falls one cycle after it rose.
- R5: If bit 13 of the update command is set, the update is held while `data_busy` is 1 and completes after `data_busy` drops. Without bit 13, `data_busy` does not hold the update.
- R6: A command-port write while `cmd_start` is 1 sets `hle_flag` (interrupt status bit 12) and leaves the pending update, including its wait condition, unchanged.
- R7: A write to the status-clear port (`wr_sel`=3) with bit 12 set clears `hle_flag`. With bit 12 clear it has no effect.
- R8: With run=1 and divider N≥1, `cclk_tick` pulses once every 2N cycles. With N=0 it is high on every cycle.
- R9: With run=0, `cclk_tick` and `cclk_level` stay 0.
- R10: An update is applied only in a cycle where `cclk_level` is 0. A request issued in the high half waits for the low half.
- R11: A command-port write with bit 31 set but bit 21 clear does not set `cmd_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 staged divider, 1 staged run bit, 2 command, 3 status clear |
| wr_data | input | 32 | Write data |
| data_busy | input | 1 | Data path busy, gates updates that request waiting |
| cmd_start | output | 1 | Command start bit readback, 1 while an update is pending |
| hle_flag | output | 1 | Hardware-locked error status (status bit 12) |
| div_active | output | 8 | Divider value in force |
| ena_active | output | 1 | Run bit in force |
| cclk_level | output | 1 | Card-clock level |
| cclk_tick | output | 1 | One-cycle enable at each card-clock rising edge |

## Verification
A command write sampled on one edge shows `cmd_start` high after that edge. With the level low and no busy hold, the new divider settings appear one edge later, at the same moment `cmd_start` falls. The bench drives inputs on falling edges and checks outputs one or two falling edges after each write, matching those register stages. Completion times that depend on busy or on the card-clock phase are checked by a monitor: at every fall of `cmd_start` it compares the settings in force against a queue of expected configurations. Divider period is measured by counting cycles between successive ticks.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    localparam int unsigned CC_DIV_W   = 8;
    localparam int unsigned CC_WORD_W  = 32;

    localparam int unsigned CMD_GO_BIT   = 31;
    localparam int unsigned CMD_UPD_BIT  = 21;
    localparam int unsigned CMD_WAIT_BIT = 13;
    localparam int unsigned STS_LOCK_BIT = 12;

    typedef enum logic [1:0] {
        SEL_DIVIDER = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_COMMAND = 2'd2,
        SEL_INTCLR  = 2'd3
    } cc_sel_e;

    typedef struct packed {
        logic [CC_DIV_W-1:0] div;
        logic                ena;
    } cc_cfg_t;

    typedef struct packed {
        logic go;
        logic upd;
        logic wait_prv;
    } cc_cmd_t;

    function automatic cc_cmd_t cc_decode(input logic [CC_WORD_W-1:0] w);
        cc_cmd_t c;
        c.go       = w[CMD_GO_BIT];
        c.upd      = w[CMD_UPD_BIT];
        c.wait_prv = w[CMD_WAIT_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cardclk_regs.sv
module cardclk_regs
    import cardclk_pkg::*;
#(
    parameter int unsigned WORD_W = CC_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start_pending,
    output cc_cfg_t           staged,
    output logic              lock_err,
    output logic              cmd_accept,
    output cc_cmd_t           cmd_fields
);

    cc_sel_e sel;
    cc_cfg_t staged_q;
    logic    lock_q;
    logic    cmd_wr;

    assign sel        = cc_sel_e'(wr_sel);
    assign cmd_wr     = wr_en && (sel == SEL_COMMAND);
    assign cmd_accept = cmd_wr && !start_pending;
    assign cmd_fields = cc_decode(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
        end else if (wr_en && (sel == SEL_DIVIDER)) begin
            staged_q.div <= wr_data[CC_DIV_W-1:0];
        end else if (wr_en && (sel == SEL_ENABLE)) begin
            staged_q.ena <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (cmd_wr && start_pending) begin
            lock_q <= 1'b1;
        end else if (wr_en && (sel == SEL_INTCLR) && wr_data[STS_LOCK_BIT]) begin
            lock_q <= 1'b0;
        end
    end

    assign staged   = staged_q;
    assign lock_err = lock_q;

endmodule

// File: rtl/cardclk_handshake.sv
module cardclk_handshake
    import cardclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_accept,
    input  cc_cmd_t cmd_fields,
    input  logic    data_busy,
    input  logic    low_phase,
    output logic    pending,
    output logic    apply
);

    logic pend_q;
    logic wait_q;

    assign apply   = pend_q && (!wait_q || !data_busy) && low_phase;
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            wait_q <= 1'b0;
        end else if (cmd_accept && cmd_fields.go && cmd_fields.upd) begin
            pend_q <= 1'b1;
            wait_q <= cmd_fields.wait_prv;
        end else if (apply) begin
            pend_q <= 1'b0;
            wait_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cardclk_counter.sv
module cardclk_counter
    import cardclk_pkg::*;
#(
    parameter int unsigned DIV_W = CC_DIV_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    apply,
    input  cc_cfg_t staged,
    output cc_cfg_t active,
    output logic    level,
    output logic    tick,
    output logic    low_phase
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    cc_cfg_t          act_q;
    logic [DIV_W-1:0] cnt_q;
    logic             lvl_q;
    logic             bypass;
    logic             half_end;

    assign bypass   = (act_q.div == '0);
    assign half_end = (cnt_q == (act_q.div - ONE));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (apply) begin
            act_q <= staged;
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (!act_q.ena || bypass) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (half_end) begin
            cnt_q <= '0;
            lvl_q <= !lvl_q;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign active    = act_q;
    assign level     = lvl_q;
    assign low_phase = !lvl_q;
    assign tick      = act_q.ena && (bypass || (!lvl_q && half_end));

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [CC_WORD_W-1:0] wr_data,
    input  logic                 data_busy,
    output logic                 cmd_start,
    output logic                 hle_flag,
    output logic [CC_DIV_W-1:0]  div_active,
    output logic                 ena_active,
    output logic                 cclk_level,
    output logic                 cclk_tick
);

    cc_cfg_t staged;
    cc_cfg_t active;
    cc_cmd_t cmd_fields;
    logic    cmd_accept;
    logic    pending;
    logic    apply;
    logic    low_phase;

    cardclk_regs #(.WORD_W(CC_WORD_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .start_pending(pending),
        .staged       (staged),
        .lock_err     (hle_flag),
        .cmd_accept   (cmd_accept),
        .cmd_fields   (cmd_fields)
    );

    cardclk_handshake u_hs (
        .clk       (clk),
        .rst       (rst),
        .cmd_accept(cmd_accept),
        .cmd_fields(cmd_fields),
        .data_busy (data_busy),
        .low_phase (low_phase),
        .pending   (pending),
        .apply     (apply)
    );

    cardclk_counter #(.DIV_W(CC_DIV_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .apply    (apply),
        .staged   (staged),
        .active   (active),
        .level    (cclk_level),
        .tick     (cclk_tick),
        .low_phase(low_phase)
    );

    assign cmd_start  = pending;
    assign div_active = active.div;
    assign ena_active = active.ena;

endmodule

// File: rtl/cardclk_gen_chk.sv
module cardclk_gen_chk
    import cardclk_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [1:0]           wr_sel,
    input logic [CC_WORD_W-1:0] wr_data,
    input logic                 data_busy,
    input logic                 cmd_start,
    input logic                 hle_flag,
    input logic [CC_DIV_W-1:0]  div_active,
    input logic                 ena_active,
    input logic                 cclk_level,
    input logic                 cclk_tick
);

    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_sel == SEL_COMMAND);

    p_start_set_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_data[CMD_GO_BIT] && wr_data[CMD_UPD_BIT] && !cmd_start) |=> cmd_start);

    p_active_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$fell(cmd_start) |-> ($stable(div_active) && $stable(ena_active)));

    p_lock_set_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_start) |=> hle_flag);

    p_lock_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == SEL_INTCLR) && wr_data[STS_LOCK_BIT]) |=> !hle_flag);

    p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !ena_active |-> (!cclk_tick && !cclk_level));

    p_low_apply_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_start) |-> !$past(cclk_level));

    p_no_update_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_data[CMD_GO_BIT] && !wr_data[CMD_UPD_BIT] && !cmd_start) |=> !cmd_start);

endmodule

bind cardclk_gen cardclk_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .data_busy (data_busy),
    .cmd_start (cmd_start),
    .hle_flag  (hle_flag),
    .div_active(div_active),
    .ena_active(ena_active),
    .cclk_level(cclk_level),
    .cclk_tick (cclk_tick)
);

// File: tb/sim_cardclk_gen.sv
module sim_cardclk_gen;
    import cardclk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        data_busy = 1'b0;
    logic        cmd_start;
    logic        hle_flag;
    logic [7:0]  div_active;
    logic        ena_active;
    logic        cclk_level;
    logic        cclk_tick;

    int n_chk  = 0;
    int n_fail = 0;
    cc_cfg_t exp_q[$];
    logic prev_start = 1'b0;

    localparam logic [31:0] W_GO   = 32'h8000_0000;
    localparam logic [31:0] W_UPD  = 32'h0020_0000;
    localparam logic [31:0] W_WAIT = 32'h0000_2000;
    localparam logic [31:0] W_LOCK = 32'h0000_1000;

    always #10 clk = ~clk;

    cardclk_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .data_busy(data_busy), .cmd_start(cmd_start), .hle_flag(hle_flag),
        .div_active(div_active), .ena_active(ena_active),
        .cclk_level(cclk_level), .cclk_tick(cclk_tick)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic stage(input logic [7:0] d, input logic e);
        wr(SEL_DIVIDER, {24'd0, d});
        wr(SEL_ENABLE, {31'd0, e});
    endtask

    task automatic send_cmd(input logic [31:0] w, input bit push, input logic [7:0] d, input logic e);
        cc_cfg_t c;
        c.div = d; c.ena = e;
        if (push) exp_q.push_back(c);
        wr(SEL_COMMAND, w);
    endtask

    task automatic wait_clear(input string tag, output int cyc);
        cyc = 0;
        while (cmd_start && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(tag, {31'd0, cmd_start}, 32'd0);
    endtask

    task automatic tick_gap(input string tag, input int exp);
        int g;
        int lim;
        lim = 0;
        while (!cclk_tick && lim < 600) begin @(negedge clk); lim++; end
        g = 0;
        do begin @(negedge clk); g++; end while (!cclk_tick && g < 600);
        chk(tag, g, exp);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Scoreboard monitor: each completion of an update pops one expected config.
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_start && !cmd_start) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected completion", 32'd1, 32'd0);
                end else begin
                    cc_cfg_t e;
                    e = exp_q.pop_front();
                    chk("R2 applied config", {23'd0, div_active, ena_active}, {23'd0, e.div, e.ena});
                end
            end
            prev_start = cmd_start;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int cyc;
        bit all_ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 start", {31'd0, cmd_start}, 0);
        chk("R1 hle", {31'd0, hle_flag}, 0);
        chk("R1 active", {23'd0, div_active, ena_active}, 0);
        chk("R1 clock", {30'd0, cclk_level, cclk_tick}, 0);

        // R3 staged writes do not take effect
        stage(8'd3, 1'b1);
        repeat (3) @(negedge clk);
        chk("R3 active unchanged", {23'd0, div_active, ena_active}, 0);
        chk("R3 no tick", {31'd0, cclk_tick}, 0);

        // R11 start without update bit ignored
        wr(SEL_COMMAND, W_GO);
        chk("R11 start not set", {31'd0, cmd_start}, 0);
        @(negedge clk);
        chk("R11 active unchanged", {23'd0, div_active, ena_active}, 0);

        // R2 / R4 update handshake
        send_cmd(W_GO | W_UPD, 1, 8'd3, 1'b1);
        chk("R2 start set", {31'd0, cmd_start}, 1);
        chk("R2 not applied early", {23'd0, div_active, ena_active}, 0);
        @(negedge clk);
        chk("R4 start cleared after one cycle", {31'd0, cmd_start}, 0);

        // R8 period 2N
        tick_gap("R8 period N=3", 6);
        tick_gap("R8 period N=3 again", 6);

        // R8 N=0 bypass
        stage(8'd0, 1'b1);
        send_cmd(W_GO | W_UPD, 1, 8'd0, 1'b1);
        wait_clear("R10 bypass update done", cyc);
        all_ok = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!cclk_tick) all_ok = 0;
        end
        chk("R8 tick every cycle at N=0", {31'd0, all_ok}, 1);

        // R9 stopped clock
        stage(8'd2, 1'b0);
        send_cmd(W_GO | W_UPD, 1, 8'd2, 1'b0);
        wait_clear("R9 stop update done", cyc);
        all_ok = 1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cclk_tick || cclk_level) all_ok = 0;
        end
        chk("R9 quiet when stopped", {31'd0, all_ok}, 1);

        // R5 wait for data busy
        stage(8'd2, 1'b1);
        data_busy = 1'b1;
        send_cmd(W_GO | W_UPD | W_WAIT, 1, 8'd2, 1'b1);
        repeat (4) @(negedge clk);
        chk("R5 held while busy", {31'd0, cmd_start}, 1);
        chk("R5 active unchanged while busy", {23'd0, div_active, ena_active}, {23'd0, 8'd2, 1'b0});

        // R6 rewrite while pending
        send_cmd(W_GO | W_UPD, 0, 8'd0, 1'b0);
        chk("R6 hle set", {31'd0, hle_flag}, 1);
        @(negedge clk);
        chk("R6 pending wait kept", {31'd0, cmd_start}, 1);
        data_busy = 1'b0;
        wait_clear("R5 completes after busy drops", cyc);

        // R7 write-one-to-clear
        wr(SEL_INTCLR, 32'h0000_0000);
        chk("R7 zero write keeps hle", {31'd0, hle_flag}, 1);
        wr(SEL_INTCLR, W_LOCK);
        chk("R7 hle cleared", {31'd0, hle_flag}, 0);

        // R5 busy ignored without wait bit
        stage(8'd4, 1'b1);
        data_busy = 1'b1;
        send_cmd(W_GO | W_UPD, 1, 8'd4, 1'b1);
        wait_clear("R5 busy ignored", cyc);
        chk("R5 cleared within two half periods", {31'd0, (cyc <= 5)}, 1);
        data_busy = 1'b0;

        // R10 request during high half waits for low half
        stage(8'd5, 1'b1);
        @(negedge clk);
        while (cclk_level) @(negedge clk);
        while (!cclk_level) @(negedge clk);
        exp_q.push_back('{div: 8'd5, ena: 1'b1});
        wr_en = 1'b1; wr_sel = SEL_COMMAND; wr_data = W_GO | W_UPD;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        repeat (2) @(negedge clk);
        chk("R10 held during high half", {31'd0, cmd_start}, 1);
        wait_clear("R10 applied in low half", cyc);
        tick_gap("R8 period N=5", 10);

        chk("R2 all updates completed", exp_q.size(), 0);
        finish_run();
    end

endmodule